// File: doc/BRIEF.md
# Circular Mailbox Ring Engine

The engine sits on the adapter side of a host/adapter command interface. It manages one local memory that holds two equal rings of 32-bit mailboxes placed back to back: an outgoing ring through which the host posts requests, and an incoming ring through which the adapter returns completions. The host reaches the memory through a plain word-wide read/write port. The engine reaches it through a second, internal port.

A start command or a periodic scan tick makes the engine poll the outgoing ring from its current index. Every slot marked start or abort is taken: its code is cleared and its request pointer is handed to the request executor as a one-cycle pulse. The executor returns completions through a valid/ready channel. The engine writes each one, code and pointer, into the next incoming slot and then pulses a mailbox-loaded interrupt. An incoming slot that the host has not yet released stalls the completion channel until the host writes its code back to zero.

Top module: `mbox_ring_engine`

## Requirements
- R1: The memory holds 2×N words. Word index k is slot k, and slots 0..N-1 form the outgoing ring while slots N..2N-1 form the incoming ring. A word is {code[31:24], pointer[23:0]}: byte 0 is the code and bytes 1..3 hold the 24-bit pointer, most significant byte first. The host port reads with one cycle of latency.
- R2: A scan_start or scan_tick pulse starts a scan at the current outgoing index. Each consecutive slot with code 0x01 (start) or 0x02 (abort) produces one req_valid pulse in ring order, carrying that slot's pointer on req_ptr, with req_abort=1 for code 0x02.
- R3: The engine rewrites each slot it takes with code 0x00 and leaves the pointer bytes unchanged.
- R4: A scan stops at the first slot whose code is neither 0x01 nor 0x02, and it neither advances past that slot nor changes it. One scan takes at most N slots.
- R5: The outgoing index starts at 0 after reset and wraps from N-1 to 0.
- R6: An accepted completion writes {cpl_code, cpl_ptr} into the incoming slot at the incoming index. That index starts at N after reset and wraps from 2N-1 to N.
- R7: While the incoming slot at the index holds a non-zero code, cpl_ready stays low and nothing is written. Once the host writes that code to 0x00, the completion is accepted.
- R8: irq_mbox_in pulses for exactly one cycle, in the cycle after an accepted completion (cpl_valid and cpl_ready both high). It never pulses otherwise.
- R9: After reset, req_valid, cpl_ready and irq_mbox_in are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host port write enable |
| host_addr | input | AW | Host port slot index |
| host_wdata | input | 32 | Host port write word |
| host_rdata | output | 32 | Host port read word, one cycle after the address |
| scan_start | input | 1 | Host start command pulse |
| scan_tick | input | 1 | Periodic scan trigger pulse |
| req_valid | output | 1 | One-cycle pulse: a request was taken |
| req_abort | output | 1 | Taken slot carried the abort code |
| req_ptr | output | 24 | Pointer of the taken request |
| cpl_valid | input | 1 | Completion offered; held until accepted |
| cpl_code | input | 8 | Completion code (0x01 ok, 0x02 aborted, 0x03 not found, 0x04 error) |
| cpl_ptr | input | 24 | Completion pointer |
| cpl_ready | output | 1 | Completion accepted this cycle |
| irq_mbox_in | output | 1 | Incoming-mailbox-loaded interrupt pulse |

## Verification
A trigger that reaches an idle engine puts the first req_valid pulse two cycles after the edge that samples it. Each further taken slot follows two cycles after the previous one, so the bench waits 2k+10 cycles for a batch of k and then compares the queue that its monitor has collected. A completion offered to an idle engine sees cpl_ready in the third cycle. The monitor then expects irq_mbox_in at exactly the next falling-edge sample. All outputs are sampled on the falling edge, and memory contents are read back only after the engine has gone quiet, allowing for the one-cycle host read latency.

// File: rtl/mbox_ring_pkg.sv
package mbox_ring_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] OB_FREE  = 8'h00;
  localparam logic [CODE_W-1:0] OB_START = 8'h01;
  localparam logic [CODE_W-1:0] OB_ABORT = 8'h02;
  localparam logic [CODE_W-1:0] IB_FREE  = 8'h00;
  typedef enum logic [2:0] {ST_IDLE, ST_ORD, ST_OCHK, ST_IRD, ST_ICHK} eng_state_t;
endpackage

// File: rtl/ring_wrap_idx.sv
module ring_wrap_idx #(
  parameter int AW   = 7,
  parameter int BASE = 0,
  parameter int SPAN = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] FIRST = AW'(BASE);
  localparam logic [AW-1:0] LAST  = AW'(BASE + SPAN - 1);

  always_ff @(posedge clk) begin
    if (rst)       idx <= FIRST;
    else if (step) idx <= (idx == LAST) ? FIRST : idx + 1'b1;
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wd_a,
  output logic [DW-1:0] q_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wd_b,
  output logic [DW-1:0] q_b
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= wd_a;
    if (we_b) mem[addr_b] <= wd_b;
    q_a <= mem[addr_a];
    q_b <= mem[addr_b];
  end
endmodule

// File: rtl/mbox_ring_engine.sv
module mbox_ring_engine
  import mbox_ring_pkg::*;
#(
  parameter int N  = 64,
  parameter int PW = 24,
  localparam int AW = $clog2(2 * N),
  localparam int DW = CODE_W + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          scan_start,
  input  logic          scan_tick,
  output logic          req_valid,
  output logic          req_abort,
  output logic [PW-1:0] req_ptr,
  input  logic          cpl_valid,
  input  logic [CODE_W-1:0] cpl_code,
  input  logic [PW-1:0] cpl_ptr,
  output logic          cpl_ready,
  output logic          irq_mbox_in
);
  localparam logic [AW-1:0] SCAN_LAST = AW'(N - 1);

  eng_state_t state;
  logic [AW-1:0] ring_idx [2];
  logic          ring_step [2];
  logic [AW-1:0] taken_cnt;
  logic          scan_pend, trig, go_scan;
  logic          b_we, take, accept;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wd, b_q;
  logic [CODE_W-1:0] slot_code;

  // one wrapping index per ring, each with its own base
  for (genvar g = 0; g < 2; g++) begin : g_ring
    ring_wrap_idx #(.AW(AW), .BASE(g * N), .SPAN(N)) u_idx (
      .clk(clk), .rst(rst), .step(ring_step[g]), .idx(ring_idx[g])
    );
  end

  mbox_dpram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk),
    .we_a(host_we), .addr_a(host_addr), .wd_a(host_wdata), .q_a(host_rdata),
    .we_b(b_we), .addr_b(b_addr), .wd_b(b_wd), .q_b(b_q)
  );

  assign slot_code = b_q[DW-1 -: CODE_W];
  assign trig      = scan_start | scan_tick;
  assign go_scan   = (state == ST_IDLE) && (scan_pend || trig);

  assign take   = (state == ST_OCHK) &&
                  (slot_code == OB_START || slot_code == OB_ABORT);
  assign accept = (state == ST_ICHK) && (slot_code == IB_FREE) && cpl_valid;

  assign ring_step[0] = take;
  assign ring_step[1] = accept;
  assign cpl_ready    = accept;

  always_comb begin
    b_addr = (state == ST_ORD || state == ST_OCHK) ? ring_idx[0] : ring_idx[1];
    b_we   = take || accept;
    b_wd   = take ? {OB_FREE, b_q[PW-1:0]} : {cpl_code, cpl_ptr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      scan_pend   <= 1'b0;
      taken_cnt   <= '0;
      req_valid   <= 1'b0;
      req_abort   <= 1'b0;
      req_ptr     <= '0;
      irq_mbox_in <= 1'b0;
    end else begin
      scan_pend   <= go_scan ? 1'b0 : (scan_pend | trig);
      req_valid   <= take;
      irq_mbox_in <= accept;
      if (take) begin
        req_ptr   <= b_q[PW-1:0];
        req_abort <= (slot_code == OB_ABORT);
      end
      unique case (state)
        ST_IDLE: begin
          taken_cnt <= '0;
          if (go_scan)        state <= ST_ORD;
          else if (cpl_valid) state <= ST_IRD;
        end
        ST_ORD:  state <= ST_OCHK;
        ST_OCHK: begin
          taken_cnt <= taken_cnt + 1'b1;
          state     <= (take && taken_cnt != SCAN_LAST) ? ST_ORD : ST_IDLE;
        end
        ST_IRD:  state <= ST_ICHK;
        ST_ICHK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_ring_chk.sv
module mbox_ring_chk #(
  parameter int N  = 64,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          irq,
  input logic          cpl_valid,
  input logic          cpl_ready,
  input logic [AW-1:0] out_idx,
  input logic [AW-1:0] in_idx
);
  // R5: outgoing index stays inside the outgoing ring
  a_r5_out_range: assert property (@(posedge clk) disable iff (rst)
    32'(out_idx) < N);

  // R6: incoming index stays inside the incoming ring
  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    32'(in_idx) >= N && 32'(in_idx) < 2 * N);

  // R6: every accepted completion moves the incoming index
  a_r6_in_step: assert property (@(posedge clk) disable iff (rst)
    cpl_ready |=> in_idx != $past(in_idx));

  // R8: interrupt only after an accepted completion
  a_r8_irq_after_accept: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cpl_valid && cpl_ready));

  // R8: interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R2: taken requests are at least two cycles apart
  a_r2_req_gap: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R9: outputs quiet in the first cycle after reset
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !req_valid && !irq && !cpl_ready);
endmodule

bind mbox_ring_engine mbox_ring_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .irq(irq_mbox_in),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .out_idx(ring_idx[0]), .in_idx(ring_idx[1])
);

// File: tb/sim_mbox_ring_engine.sv
module sim_mbox_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int AW = $clog2(2 * N);

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic scan_start = 1'b0, scan_tick = 1'b0;
  logic req_valid, req_abort, cpl_ready, irq_mbox_in;
  logic [23:0] req_ptr;
  logic cpl_valid = 1'b0;
  logic [7:0] cpl_code = '0;
  logic [23:0] cpl_ptr = '0;

  int tests = 0, fails = 0;
  int irq_cnt = 0, acc_cnt = 0;
  int m_out = 0, m_in = N;
  logic [24:0] got_q[$];
  logic [24:0] exp_q[$];
  logic acc_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_ring_engine #(.N(N)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scan_start(scan_start), .scan_tick(scan_tick),
    .req_valid(req_valid), .req_abort(req_abort), .req_ptr(req_ptr),
    .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_ptr(cpl_ptr),
    .cpl_ready(cpl_ready), .irq_mbox_in(irq_mbox_in)
  );

  function automatic int nxt_out(int i); return (i == N - 1) ? 0 : i + 1; endfunction
  function automatic int nxt_in(int i);  return (i == 2 * N - 1) ? N : i + 1; endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: requests and interrupt timing (R2, R8)
  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid) got_q.push_back({req_abort, req_ptr});
      if (irq_mbox_in) irq_cnt++;
      if (acc_d) chk(irq_mbox_in === 1'b1, "R8 irq after accept", 32'(irq_mbox_in), 1);
      else if (irq_mbox_in) chk(1'b0, "R8 irq without accept", 1, 0);
      acc_d = cpl_valid && cpl_ready;
      if (acc_d) acc_cnt++;
    end
  end

  task automatic hwrite(int a, logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic hread(int a, output logic [31:0] d);
    @(negedge clk); host_addr = AW'(a);
    @(negedge clk); d = host_rdata;
  endtask

  task automatic trigger(bit use_tick);
    @(negedge clk);
    if (use_tick) scan_tick = 1'b1; else scan_start = 1'b1;
    @(negedge clk); scan_tick = 1'b0; scan_start = 1'b0;
  endtask

  task automatic cpl_wait(int maxc, output bit ok);
    ok = 1'b0;
    for (int c = 0; c < maxc && !ok; c++) begin
      @(negedge clk);
      if (cpl_ready) ok = 1'b1;
    end
    if (ok) begin @(posedge clk); #1 cpl_valid = 1'b0; end
  endtask

  task automatic compare_reqs(string tag);
    chk(got_q.size() == exp_q.size(), tag, 32'(got_q.size()), 32'(exp_q.size()));
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      logic [24:0] g = got_q.pop_front();
      logic [24:0] e = exp_q.pop_front();
      chk(g == e, tag, 32'(g), 32'(e));
    end
    got_q.delete(); exp_q.delete();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int written [$];
    logic [31:0] wr_word [$];
    bit ok;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    chk(!req_valid && !cpl_ready && !irq_mbox_in, "R9 reset outputs quiet",
        {29'd0, req_valid, cpl_ready, irq_mbox_in}, 0);

    for (int i = 0; i < 2 * N; i++) hwrite(i, 32'h0);

    // R4: empty ring yields nothing
    trigger(1'b0);
    repeat (10) @(negedge clk);
    compare_reqs("R4 empty scan");

    // R2/R3/R5: random batches, enough to wrap the outgoing ring
    for (int b = 0; b < 8; b++) begin
      int k = 8 + int'($urandom % 12);
      written.delete(); wr_word.delete();
      for (int s = 0; s < k; s++) begin
        logic [23:0] p = 24'($urandom);
        bit ab = ($urandom % 4) == 0;
        logic [31:0] w = {ab ? 8'h02 : 8'h01, p};
        hwrite(m_out, w);
        written.push_back(m_out); wr_word.push_back(w);
        exp_q.push_back({ab, p});
        m_out = nxt_out(m_out);
      end
      trigger(b[0]);
      repeat (2 * k + 10) @(negedge clk);
      compare_reqs("R2 R5 request order");
      for (int s = 0; s < k; s++) begin
        hread(written[s], rd);
        chk(rd == {8'h00, wr_word[s][23:0]}, "R3 slot freed pointer kept",
            rd, {8'h00, wr_word[s][23:0]});
      end
    end

    // R4: stop at an unknown code, leave it untouched
    begin
      int bad;
      hwrite(m_out, {8'h01, 24'h111111}); exp_q.push_back({1'b0, 24'h111111});
      m_out = nxt_out(m_out);
      bad = m_out;
      hwrite(bad, {8'h07, 24'h222222});
      hwrite(nxt_out(bad), {8'h01, 24'h333333});
      trigger(1'b0);
      repeat (14) @(negedge clk);
      compare_reqs("R4 stop at unknown code");
      hread(bad, rd);
      chk(rd == {8'h07, 24'h222222}, "R4 unknown slot unchanged", rd, {8'h07, 24'h222222});
      hwrite(bad, {8'h02, 24'h222222});
      exp_q.push_back({1'b1, 24'h222222}); exp_q.push_back({1'b0, 24'h333333});
      trigger(1'b1);
      repeat (14) @(negedge clk);
      compare_reqs("R4 resume at same slot");
      m_out = nxt_out(nxt_out(bad));
    end

    // R1/R6: completions, host frees each slot, wraps incoming ring
    for (int j = 0; j < N + 4; j++) begin
      logic [7:0] c = 8'(1 + ($urandom % 4));
      logic [23:0] p = 24'($urandom);
      @(negedge clk); cpl_code = c; cpl_ptr = p; cpl_valid = 1'b1;
      cpl_wait(20, ok);
      chk(ok, "R6 completion accepted", 32'(ok), 1);
      if (!ok) begin @(negedge clk); cpl_valid = 1'b0; end
      repeat (2) @(negedge clk);
      hread(m_in, rd);
      chk(rd == {c, p}, "R1 R6 incoming slot content", rd, {c, p});
      hwrite(m_in, 32'h0);
      m_in = nxt_in(m_in);
    end

    // R7: fill incoming ring without freeing, then stall
    for (int j = 0; j < N; j++) begin
      @(negedge clk); cpl_code = 8'h04; cpl_ptr = 24'(j); cpl_valid = 1'b1;
      cpl_wait(20, ok);
      if (!ok) begin chk(1'b0, "R7 fill accept", 0, 1); @(negedge clk); cpl_valid = 1'b0; end
      m_in = nxt_in(m_in);
    end
    begin
      int irq_before;
      repeat (4) @(negedge clk);
      irq_before = irq_cnt;
      @(negedge clk); cpl_code = 8'h03; cpl_ptr = 24'hABCDEF; cpl_valid = 1'b1;
      cpl_wait(40, ok);
      chk(!ok, "R7 stall while slot busy", 32'(ok), 0);
      chk(irq_cnt == irq_before, "R7 no irq while stalled", 32'(irq_cnt), 32'(irq_before));
      hread(m_in, rd);
      chk(rd == {8'h04, 24'd0}, "R7 busy slot untouched", rd, {8'h04, 24'd0});
      hwrite(m_in, 32'h0);
      cpl_wait(20, ok);
      chk(ok, "R7 accepted after host frees", 32'(ok), 1);
      if (!ok) begin @(negedge clk); cpl_valid = 1'b0; end
      repeat (2) @(negedge clk);
      hread(m_in, rd);
      chk(rd == {8'h03, 24'hABCDEF}, "R7 R6 slot written after release", rd, {8'h03, 24'hABCDEF});
    end

    repeat (4) @(negedge clk);
    chk(irq_cnt == acc_cnt, "R8 one irq per accept", 32'(irq_cnt), 32'(acc_cnt));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule